// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor whose procedure calls rotate a window over a circular stack of physical registers. At any moment software addresses 32 registers. Addresses 0 to 7 are globals, and address 0 always reads as zero. Addresses 8 to 31 fall in the current window, which is chosen by a 5-bit window pointer. Within a window, addresses 8–15 are the outgoing registers, 16–23 are the locals and 24–31 are the incoming registers.

A call strobes `save_req`, which moves the pointer one window down. The caller's outgoing registers then become the callee's incoming registers without any copy. A return strobes `restore_req`, which moves the pointer back up. The stack is circular with `NWIN` windows. A mask input marks windows that may not be entered. A rotation that would land in a marked window is refused and raises a spill or fill request flag for the surrounding trap logic. The block does not do the spill or fill itself.

There are two combinational read ports and one write port. A write is performed at the clock edge, and a read of the address being written in the same cycle returns the new data.

Top module: `windowed_regfile`

## Requirements
- R1: After reset the window pointer is 0, every register reads 0, and both flags are low when no rotation is requested.
- R2: Address 0 always reads 0 on both ports. A write to address 0 changes nothing, including the same-cycle bypass.
- R3: Addresses 1–7 name the same storage in every window.
- R4: In window w, addresses 16–23 are locals that belong to w alone. Addresses 8–15 are the outgoing set of w, and addresses 24–31 are the incoming set of w.
- R5: The incoming registers of window w-1 are the same storage as the outgoing registers of window w. This holds modulo NWIN, so the incoming set of window NWIN-1 is the outgoing set of window 0.
- R6: Without a refusal, `save_req` sets the pointer to (cwp-1) mod NWIN and `restore_req` sets it to (cwp+1) mod NWIN, both at the next edge.
- R7: When the target window's bit in `inv_mask` is 1, a save raises `win_ovf` and a restore raises `win_unf` in that same cycle, and the pointer keeps its value.
- R8: When `wr_en` is high and `wr_addr` is a nonzero address equal to a read address, that read port returns `wr_data` in the same cycle.
- R9: When `save_req` and `restore_req` are high together, only the save acts and `win_unf` stays low.
- R10: A write issued in the same cycle as a rotation lands in the window that was current before the rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr_a | input | 5 | Read port A address |
| rd_data_a | output | XLEN | Read port A data |
| rd_addr_b | input | 5 | Read port B address |
| rd_data_b | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Rotate to the next window down (call) |
| restore_req | input | 1 | Rotate to the next window up (return) |
| inv_mask | input | NWIN | One bit per window; 1 means the window may not be entered |
| cwp | output | 5 | Current window pointer |
| win_ovf | output | 1 | Save refused; spill needed |
| win_unf | output | 1 | Restore refused; fill needed |

## Verification
The bench targets the wrap of the pointer from 0 down to NWIN-1. A design that indexed windows without a modulo would read stale or wrong storage for the incoming registers of the last window there. It tests a rotation into a masked window: a wrong design would move the pointer anyway, or raise the wrong flag. It tests a write issued in the same cycle as a save, which lands in the wrong window if the new pointer is used. It also tests the bypass of a write to address 0, which would leak nonzero data on the read port. Long random runs with shifting masks compare both read ports, the pointer and both flags against a model built on per-window arrays. Those runs expose any aliasing between locals of different windows.

// File: rtl/windowed_regfile.sv
module windowed_regfile #(
  parameter int NWIN = 8,
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_addr_a,
  output logic [XLEN-1:0] rd_data_a,
  input  logic [4:0]      rd_addr_b,
  output logic [XLEN-1:0] rd_data_b,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic [NWIN-1:0] inv_mask,
  output logic [4:0]      cwp,
  output logic            win_ovf,
  output logic            win_unf
);
  localparam int TOT = NWIN * 16;
  localparam int PW  = $clog2(TOT);

  logic [XLEN-1:0] gregs [1:7];
  logic [XLEN-1:0] wregs [TOT];
  logic [4:0]      cwp_dn, cwp_up;

  function automatic logic [PW-1:0] phys(input logic [4:0] w, input logic [4:0] a);
    int s;
    s = int'(w) * 16 + int'(a) - 8;
    if (s >= TOT) s = s - TOT;
    return PW'(s);
  endfunction

  function automatic logic [XLEN-1:0] rd(input logic [4:0] a);
    if (a == 5'd0)                    return '0;
    else if (wr_en && wr_addr == a)   return wr_data;
    else if (a < 5'd8)                return gregs[a[2:0]];
    else                              return wregs[phys(cwp, a)];
  endfunction

  assign cwp_dn = (cwp == 5'd0) ? 5'(NWIN - 1) : cwp - 5'd1;
  assign cwp_up = (cwp == 5'(NWIN - 1)) ? 5'd0 : cwp + 5'd1;

  assign win_ovf = save_req & |(inv_mask & (NWIN'(1) << cwp_dn));
  assign win_unf = restore_req & ~save_req & |(inv_mask & (NWIN'(1) << cwp_up));

  assign rd_data_a = rd(rd_addr_a);
  assign rd_data_b = rd(rd_addr_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp <= 5'd0;
      for (int i = 1; i < 8; i++) gregs[i] <= '0;
      for (int i = 0; i < TOT; i++) wregs[i] <= '0;
    end else begin
      if (wr_en && wr_addr != 5'd0) begin
        if (wr_addr < 5'd8) gregs[wr_addr[2:0]] <= wr_data;
        else                wregs[phys(cwp, wr_addr)] <= wr_data;
      end
      if (save_req) begin
        if (!win_ovf) cwp <= cwp_dn;
      end else if (restore_req) begin
        if (!win_unf) cwp <= cwp_up;
      end
    end
  end
endmodule

module wrf_chk #(
  parameter int NWIN = 8,
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      rd_addr_a,
  input logic [XLEN-1:0] rd_data_a,
  input logic [4:0]      rd_addr_b,
  input logic [XLEN-1:0] rd_data_b,
  input logic            wr_en,
  input logic [4:0]      wr_addr,
  input logic [XLEN-1:0] wr_data,
  input logic            save_req,
  input logic            restore_req,
  input logic [4:0]      cwp,
  input logic            win_ovf,
  input logic            win_unf
);
  // R2
  zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_a == 5'd0 |-> rd_data_a == '0);
  // R2
  zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_b == 5'd0 |-> rd_data_b == '0);
  // R6
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cwp) < NWIN);
  // R6
  save_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_req && !win_ovf |=>
      cwp == (($past(cwp) == 5'd0) ? 5'(NWIN - 1) : $past(cwp) - 5'd1));
  // R6
  restore_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req && !save_req && !win_unf |=>
      cwp == (($past(cwp) == 5'(NWIN - 1)) ? 5'd0 : $past(cwp) + 5'd1));
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_ovf |=> cwp == $past(cwp));
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_unf |=> cwp == $past(cwp));
  // R8
  bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr != 5'd0 && wr_addr == rd_addr_a |-> rd_data_a == wr_data);
  // R9
  save_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_req && restore_req |-> !win_unf);
endmodule

bind windowed_regfile wrf_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
  .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .save_req(save_req),
  .restore_req(restore_req), .cwp(cwp), .win_ovf(win_ovf), .win_unf(win_unf));

// File: tb/test_windowed_regfile.sv
module test_windowed_regfile;
  localparam int N = 8;
  localparam int XL = 32;

  logic clk = 0, rst_n = 0;
  logic [4:0] rd_addr_a = 0, rd_addr_b = 0, wr_addr = 0, cwp;
  logic [XL-1:0] rd_data_a, rd_data_b, wr_data = 0;
  logic wr_en = 0, save_req = 0, restore_req = 0, win_ovf, win_unf;
  logic [N-1:0] inv_mask = 0;

  windowed_regfile #(.NWIN(N), .XLEN(XL)) i_windowed_regfile (
    .clk(clk), .rst_n(rst_n), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .save_req(save_req),
    .restore_req(restore_req), .inv_mask(inv_mask), .cwp(cwp),
    .win_ovf(win_ovf), .win_unf(win_unf));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [XL-1:0] m_g [8];
  logic [XL-1:0] m_out [N][8];
  logic [XL-1:0] m_loc [N][8];
  int m_w = 0;

  function automatic logic [XL-1:0] mread(int w, int a);
    if (a == 0) return '0;
    if (a < 8)  return m_g[a];
    if (a < 16) return m_out[w][a-8];
    if (a < 24) return m_loc[w][a-16];
    return m_out[(w+1)%N][a-24];
  endfunction

  task automatic chk(string tag, string what, logic [XL-1:0] act, logic [XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [4:0] ra, logic [4:0] rb, logic we,
                      logic [4:0] wa, logic [XL-1:0] wd, logic sv, logic rs,
                      logic [N-1:0] msk);
    logic [XL-1:0] ea, eb;
    int dn, up;
    logic eo, eu;
    rd_addr_a = ra; rd_addr_b = rb; wr_en = we; wr_addr = wa; wr_data = wd;
    save_req = sv; restore_req = rs; inv_mask = msk;
    dn = (m_w + N - 1) % N;
    up = (m_w + 1) % N;
    eo = sv && msk[dn];
    eu = rs && !sv && msk[up];
    ea = (we && wa == ra && ra != 0) ? wd : mread(m_w, int'(ra));
    eb = (we && wa == rb && rb != 0) ? wd : mread(m_w, int'(rb));
    #2;
    chk(tag, "rd_data_a", rd_data_a, ea);
    chk(tag, "rd_data_b", rd_data_b, eb);
    chk(tag, "cwp", XL'(cwp), XL'(m_w));
    chk(tag, "win_ovf", XL'(win_ovf), XL'(eo));
    chk(tag, "win_unf", XL'(win_unf), XL'(eu));
    @(posedge clk);
    if (we && wa != 0) begin
      if (wa < 8)       m_g[wa] = wd;
      else if (wa < 16) m_out[m_w][wa-8] = wd;
      else if (wa < 24) m_loc[m_w][wa-16] = wd;
      else              m_out[up][wa-24] = wd;
    end
    if (sv) begin if (!eo) m_w = dn; end
    else if (rs) begin if (!eu) m_w = up; end
    @(negedge clk);
  endtask

  task automatic rdpair(string tag, int a, int b);
    step(tag, 5'(a), 5'(b), 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_g[i] = '0;
    for (int w = 0; w < N; w++)
      for (int k = 0; k < 8; k++) begin m_out[w][k] = '0; m_loc[w][k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, all addresses read zero
    for (int a = 0; a < 32; a += 2) rdpair("R1", a, a + 1);
    // R2: writes to address 0 are discarded, bypass included
    step("R2", 0, 0, 1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    rdpair("R2", 0, 0);
    // R3: globals survive rotation
    for (int a = 1; a < 8; a++) step("R3", 5'(a), 0, 1, 5'(a), 32'h100 + a, 0, 0, 0);
    step("R3", 1, 7, 0, 0, 0, 1, 0, 0);
    for (int a = 1; a < 8; a++) rdpair("R3", a, a);
    step("R3", 0, 0, 0, 0, 0, 0, 1, 0);
    // R4: outs and locals of window 0
    for (int k = 0; k < 8; k++) step("R4", 0, 0, 1, 5'(8 + k), 32'hA000 + k, 0, 0, 0);
    for (int k = 0; k < 8; k++) step("R4", 0, 0, 1, 5'(16 + k), 32'hB000 + k, 0, 0, 0);
    // R5: save from 0 wraps to NWIN-1; its ins alias window 0 outs
    step("R5", 8, 16, 0, 0, 0, 1, 0, 0);
    for (int k = 0; k < 8; k++) rdpair("R5", 24 + k, 16 + k);
    // R4: locals of window NWIN-1 untouched
    for (int k = 0; k < 8; k++) step("R4", 16 + k, 24 + k, 1, 5'(16 + k), 32'hC000 + k, 0, 0, 0);
    // R7: save into masked window refused
    step("R7", 24, 8, 0, 0, 0, 1, 0, 8'b0100_0000);
    rdpair("R7", 24, 16);
    // R6: restore twice back to window 1
    step("R6", 16, 8, 0, 0, 0, 0, 1, 0);
    rdpair("R6", 16, 8);
    step("R6", 16, 8, 0, 0, 0, 0, 1, 0);
    // R7: restore into masked window refused
    step("R7", 16, 24, 0, 0, 0, 0, 1, 8'b0000_0100);
    rdpair("R7", 16, 24);
    // R8: bypass on both ports
    step("R8", 9, 9, 1, 9, 32'hDEAD_BEEF, 0, 0, 0);
    step("R8", 3, 20, 1, 20, 32'h1234_5678, 0, 0, 0);
    rdpair("R8", 9, 20);
    // R9: simultaneous save and restore, save wins, unf stays low
    step("R9", 0, 0, 0, 0, 0, 1, 1, 8'b0000_0100);
    rdpair("R9", 8, 24);
    // R10: write with save uses old window
    step("R10", 8, 0, 1, 8, 32'h5A5A_0010, 1, 0, 0);
    rdpair("R10", 24, 8);
    step("R10", 8, 0, 0, 0, 0, 0, 1, 0);
    // R6: random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] msk;
      int r;
      r = $urandom_range(0, 3);
      msk = (r == 0) ? N'(1) << $urandom_range(0, N - 1) : '0;
      step("R6", 5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)),
           1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)), $urandom,
           ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0), msk);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule